// File: doc/BRIEF.md
# Wrap-Detecting Countdown Timer

This block holds a down-counting timer register, 32 bits wide by default, that asks for a timer interrupt once its value runs past zero. The timer does not count on every core clock. It counts only on cycles where an external timebase asserts a tick enable, so the count rate is set by whatever drives that tick. Software can load a new count through a write port at any time. The current count is always visible on a read port.

An interrupt is raised when the count steps down from all zeros to all ones, which is a 0-to-1 change of the top bit caused by a counting step. That event sets a sticky pending flag. The flag stays set until the exception sequencer acknowledges it. The request output is the pending flag gated by the processor's external-interrupt enable bit. A masked event is therefore not lost: it appears as soon as the enable is set again. The request output is registered. A software load never raises the interrupt, even when the loaded value has its top bit set.

Top module: `wrap_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count becomes all ones (the default `RST_COUNT`), the pending flag clears and `irq_req` is 0 after that edge.
- R2: On an edge with `tick_en`=1 and `wr_en`=0, the count decreases by exactly one (modulo 2^W). With neither `tick_en` nor `wr_en` high, the count holds its value.
- R3: On an edge with `wr_en`=1, the count takes `wr_data`. A write takes priority over a tick in the same cycle, so that tick has no effect.
- R4: A counting step from 0 to all ones sets the pending flag. If `int_en`=1 at that edge, `irq_req` is 1 right after it.
- R5: A counting step from any nonzero value, including the step from 0x80000000 to 0x7FFFFFFF, does not set the pending flag.
- R6: A write never sets the pending flag. This holds when `wr_data` has its top bit set, and when the count is 0 and a tick arrives in the same cycle as the write.
- R7: `irq_req` after an edge equals the pending flag AND the `int_en` sampled at that edge. While `int_en`=0, the pending flag is kept, and it is presented once `int_en` returns to 1.
- R8: `ack`=1 at an edge clears the pending flag, and `irq_req` is 0 after it. If a wrap happens at the same edge, the wrap wins and the flag stays set.
- R9: `rd_data` is the registered count. A tick or write shows on `rd_data` only after the edge that takes it, never in the cycle in which it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick: count down by one on this edge |
| wr_en | input | 1 | Software write strobe for the count |
| wr_data | input | W | Value loaded when `wr_en` is high |
| int_en | input | 1 | External-interrupt enable bit of the machine state |
| ack | input | 1 | Exception sequencer has taken the timer interrupt |
| rd_data | output | W | Current count |
| irq_req | output | 1 | Timer interrupt request, registered |

## Verification
The count path is driven with single ticks, idle cycles and writes that collide with ticks. These patterns separate a correct decrement from hold or load faults, and they show whether a write wins over a tick. The wrap path is run through the true zero crossing and through the top-bit 1-to-0 step at 0x80000000. It is also run through writes of values with the top bit set and a write at zero that collides with a tick. Together these show that only a counted 0-to-all-ones step arms the request. The enable and acknowledge are exercised with a masked wrap that is revealed later and with an acknowledge that lands on the same edge as a new wrap. These cases show that the flag is sticky and has the right priority.

// File: rtl/wt_pkg.sv
package wt_pkg;
  // What the count register does on a given edge
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_STEP = 2'd1,
    CNT_LOAD = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/wt_counter.sv
module wt_counter #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_COUNT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count_q,
  output logic         wrap_o
);
  import wt_pkg::*;
  localparam int MSB = W - 1;
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  cnt_op_e      op;
  logic [W-1:0] dec_val;

  always_comb begin
    if (wr_en)        op = CNT_LOAD;
    else if (tick_en) op = CNT_STEP;
    else              op = CNT_HOLD;
  end

  assign dec_val = count_q - ONE;

  // Wrap: a counting step turns the top bit from 0 to 1 (only from zero)
  assign wrap_o = (op == CNT_STEP) && !count_q[MSB] && dec_val[MSB];

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= RST_COUNT;
    end else begin
      unique case (op)
        CNT_LOAD: count_q <= wr_data;
        CNT_STEP: count_q <= dec_val;
        default:  count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/wt_pending.sv
module wt_pending (
  input  logic clk,
  input  logic rst,
  input  logic wrap_i,
  input  logic ack,
  input  logic int_en,
  output logic pend_q,
  output logic irq_q
);
  logic pend_d;

  // A new wrap outranks an acknowledge on the same edge
  assign pend_d = wrap_i | (pend_q & ~ack);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= pend_d & int_en;
    end
  end
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer #(
  parameter int W = 32,
  parameter logic [W-1:0] RST_COUNT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         int_en,
  input  logic         ack,
  output logic [W-1:0] rd_data,
  output logic         irq_req
);
  logic wrap;
  logic pend;

  wt_counter #(.W(W), .RST_COUNT(RST_COUNT)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .count_q (rd_data),
    .wrap_o  (wrap)
  );

  wt_pending u_pend (
    .clk    (clk),
    .rst    (rst),
    .wrap_i (wrap),
    .ack    (ack),
    .int_en (int_en),
    .pend_q (pend),
    .irq_q  (irq_req)
  );
endmodule

// File: rtl/wrap_timer_chk.sv
module wrap_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         tick_en,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         int_en,
  input logic         ack,
  input logic [W-1:0] rd_data,
  input logic         irq_req
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
  logic step, zero_step;
  assign step      = tick_en && !wr_en;
  assign zero_step = step && (rd_data == '0);

  AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
    step |=> rd_data == $past(rd_data) - ONE); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_en) |=> $stable(rd_data)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data)); // R3
  AST_WRAP_RAISES: assert property (@(posedge clk) disable iff (rst)
    (zero_step && int_en) |=> irq_req); // R4
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !irq_req); // R7
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
    (ack && !zero_step) |=> !irq_req); // R8
  AST_NO_WRITE_RAISE: assert property (@(posedge clk) disable iff (rst)
    (!irq_req && wr_en) |=> !irq_req || $past(int_en) && !$past(ack)); // R6
endmodule

bind wrap_timer wrap_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick_en (tick_en),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .int_en  (int_en),
  .ack     (ack),
  .rd_data (rd_data),
  .irq_req (irq_req)
);

// File: tb/wrap_timer_tb.sv
`timescale 1ns/1ps
module wrap_timer_tb;
  localparam int W = 32;
  localparam int NV = 20;

  typedef struct packed {
    logic         wr;
    logic [W-1:0] wd;
    logic         tk;
    logic         ee;
    logic         ak;
    logic [W-1:0] exp_rd;
    logic         exp_irq;
    logic [7:0]   req;
  } vec_t;

  // Starting state after reset: count all ones, nothing pending
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 32'h0000_0003, 1'b0, 8'd3}, // R3 load
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0002, 1'b0, 8'd2}, // R2 step
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0001, 1'b0, 8'd2}, // R2 step
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'h0000_0001, 1'b0, 8'd2}, // R2 hold
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 8'd5}, // R5 1->0 no irq
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd4}, // R4 wrap
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 8'd8}, // R8 ack
    '{1'b1, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 8'd6}, // R6 write msb
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'h7FFF_FFFF, 1'b0, 8'd5}, // R5 msb 1->0
    '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 8'd3}, // R3 load zero
    '{1'b0, 32'h0,         1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd7}, // R7 masked wrap
    '{1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd7}, // R7 still masked
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, 8'd7}, // R7 revealed
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 8'd8}, // R8 ack
    '{1'b1, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 8'd3}, // R3 load zero
    '{1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0, 8'd6}, // R6 write+tick at 0
    '{1'b1, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 8'd3}, // R3 write beats tick
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b1, 8'd8}, // R8 wrap beats ack
    '{1'b0, 32'h0,         1'b0, 1'b1, 1'b1, 32'hFFFF_FFFF, 1'b0, 8'd8}, // R8 ack
    '{1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 32'hFFFF_FFFE, 1'b0, 8'd5}  // R5 no irq
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         tick_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         int_en = 1'b0;
  logic         ack = 1'b0;
  logic [W-1:0] rd_data;
  logic         irq_req;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  wrap_timer #(.W(W)) u_dut (
    .clk (clk), .rst (rst), .tick_en (tick_en), .wr_en (wr_en),
    .wr_data (wr_data), .int_en (int_en), .ack (ack),
    .rd_data (rd_data), .irq_req (irq_req)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [W-1:0] d, input logic t,
                       input logic e, input logic a);
    wr_en = w; wr_data = d; tick_en = t; int_en = e; ack = a;
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 rd", rd_data, 32'hFFFF_FFFF);
    check("R1 irq", {31'b0, irq_req}, 32'h0);
    rst = 1'b0;

    foreach (VECS[i]) begin
      drive(VECS[i].wr, VECS[i].wd, VECS[i].tk, VECS[i].ee, VECS[i].ak);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d rd", VECS[i].req, i), rd_data, VECS[i].exp_rd);
      check($sformatf("R%0d vec%0d irq", VECS[i].req, i), {31'b0, irq_req},
            {31'b0, VECS[i].exp_irq});
    end

    // R9: a tick shows only after the edge
    drive(1'b1, 32'h0000_000A, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(1'b0, '0, 1'b1, 1'b1, 1'b0);
    #1 check("R9 same cycle", rd_data, 32'h0000_000A);
    @(posedge clk); @(negedge clk);
    check("R9 next cycle", rd_data, 32'h0000_0009);

    // R1: reset in the middle of a pending request
    drive(1'b1, '0, 1'b0, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    drive(1'b0, '0, 1'b1, 1'b1, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R4 wrap before reset", {31'b0, irq_req}, 32'h1);
    drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 reset rd", rd_data, 32'hFFFF_FFFF);
    check("R1 reset irq", {31'b0, irq_req}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R1 pending gone", {31'b0, irq_req}, 32'h0);

    finish_up();
  end
endmodule